// File: doc/BRIEF.md
# Register-File ALU Datapath

This block is the data half of a small processor core. It holds a bank of general-purpose registers with one write port and two read ports, a two-operand arithmetic/logic unit, a selector that picks the ALU's first operand, and a result selector. The result selector's output does two jobs. It is the data written back into the register bank, and it is the word presented on the datapath output when that output is enabled. A separate control unit, which is not part of this block, drives every select, address and enable on each cycle.

A typical instruction takes one clock. The controller sets the read addresses and port enables, picks the operand and result sources and the ALU operation, and raises the write enable. The selected value lands in the target register on the next rising edge. Reads are combinational, so the freshly written value can be looked at in the following cycle without a wait state. The ALU flags are always visible. They let the controller test a result whether or not that result is written back or driven out.

Top module: `dp_core`

## Requirements
- R1: A synchronous active-high `rst` clears all eight registers to zero on the rising clock edge; a read of any register right after reset returns zero.
- R2: When `wr_en` is high and `rst` is low, the register addressed by `wr_addr` takes the result-selector value at the rising clock edge.
- R3: Read ports A and B are combinational: with the port enabled, the port shows the addressed register in the same cycle, including a value written at the immediately preceding edge.
- R4: A read port whose enable is low yields all zeros on that port.
- R5: `res_sel` picks the result: 0 = memory word, 1 = immediate word, 2 = read port A, 3 = read port B, 4 = ALU result; codes 5 to 7 give zero.
- R6: `opa_sel` picks ALU operand A: 0 = memory word, 1 = immediate word, 2 = read port A; code 3 gives zero. ALU operand B is always read port B.
- R7: `dp_out` equals the result-selector value while `out_en` is high and is zero while it is low; `out_en` has no effect on what is written back.
- R8: `alu_op` encodings: 0 = pass operand A, 1 = A + B, 2 = A − B, 3 = A AND B, 4 = A OR B, 5 = A XOR B; codes 6 and 7 give zero. Arithmetic wraps modulo 2^W.
- R9: `flags[0]` is high when the ALU result is zero. `flags[1]` is the carry-out for addition and the borrow (A < B unsigned) for subtraction, and zero for every other operation. `flags[2]` is the result MSB. The flags are combinational and independent of `res_sel` and `out_en`.
- R10: A register-to-register move (res_sel = 3, write enabled) copies the source register into the destination in one cycle.
- R11: With `wr_en` low, no register changes, whatever the selects and data present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the register bank |
| mem_word | input | W | Word from main memory |
| imm_word | input | W | Immediate word from the instruction |
| out_en | input | 1 | Enables the datapath output |
| alu_op | input | 3 | ALU operation code |
| res_sel | input | 3 | Result / writeback source select |
| opa_sel | input | 2 | ALU operand A source select |
| wr_addr | input | 3 | Register write address |
| wr_en | input | 1 | Register write enable |
| rd_addr_a | input | 3 | Read port A address |
| rd_en_a | input | 1 | Read port A enable |
| rd_addr_b | input | 3 | Read port B address |
| rd_en_b | input | 1 | Read port B enable |
| dp_out | output | W | Gated datapath result |
| flags | output | 3 | ALU flags {negative, carry, zero} |

## Verification
A scripted instruction sequence comes first. It loads constants, moves one register to another, adds two registers, and adds an immediate to a register. Each value is read back in the cycle right after its write, which separates a combinational read from a registered one and shows that the result selector feeds the write port. Long random streams then vary every select, operation, address and enable, including the unused codes, disabled ports and writes with output gating. A behavioural model predicts the output and flags for each cycle, so wrong source mapping, swapped operands, a missing borrow or carry, and writes that leak while disabled each give a mismatch. Occasional resets mid-stream, followed by reads of every register, check the clearing behaviour.

// File: rtl/dp_pkg.sv
package dp_pkg;

    localparam int REG_COUNT = 8;
    localparam int ADDR_W    = $clog2(REG_COUNT);

    typedef enum logic [2:0] {
        OP_PASS = 3'd0,
        OP_ADD  = 3'd1,
        OP_SUB  = 3'd2,
        OP_AND  = 3'd3,
        OP_OR   = 3'd4,
        OP_XOR  = 3'd5
    } alu_op_e;

    typedef enum logic [2:0] {
        RES_MEM  = 3'd0,
        RES_IMM  = 3'd1,
        RES_PA   = 3'd2,
        RES_PB   = 3'd3,
        RES_ALU  = 3'd4
    } res_src_e;

    typedef enum logic [1:0] {
        OPA_MEM = 2'd0,
        OPA_IMM = 2'd1,
        OPA_PA  = 2'd2
    } opa_src_e;

    localparam int FLAG_ZERO  = 0;
    localparam int FLAG_CARRY = 1;
    localparam int FLAG_NEG   = 2;

endpackage

// File: rtl/dp_regfile.sv
module dp_regfile #(
    parameter int W      = 32,
    parameter int NREG   = 8,
    parameter int AW     = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_en_a,
    input  logic [AW-1:0] rd_addr_a,
    input  logic          rd_en_b,
    input  logic [AW-1:0] rd_addr_b,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b
);

    logic [W-1:0] bank [NREG];

    genvar gi;
    generate
        for (gi = 0; gi < NREG; gi++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    bank[gi] <= '0;
                end else if (wr_en && (wr_addr == AW'(gi))) begin
                    bank[gi] <= wr_data;
                end
            end
        end
    endgenerate

    always_comb begin
        rd_a = rd_en_a ? bank[rd_addr_a] : '0;
        rd_b = rd_en_b ? bank[rd_addr_b] : '0;
    end

    // R1: every register reads zero in the first cycle after reset
    a_r1_clear_a: assert property (@(posedge clk)
        $fell(rst) |-> (!rd_en_a || rd_a == '0));
    a_r1_clear_b: assert property (@(posedge clk)
        $fell(rst) |-> (!rd_en_b || rd_b == '0));

    // R3: a value written at one edge is readable on port A in the next cycle
    a_r3_fresh_read: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (!rd_en_a || rd_addr_a != $past(wr_addr) || rd_a == $past(wr_data)));

    // R2: the write lands at the addressed register
    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (!rd_en_b || rd_addr_b != $past(wr_addr) || rd_b == $past(wr_data)));

endmodule

// File: rtl/dp_alu.sv
module dp_alu
    import dp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [2:0]   op,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    output logic [W-1:0] result,
    output logic [2:0]   flags
);

    logic [W:0] wide;
    logic [W:0] ext_a;
    logic [W:0] ext_b;

    always_comb begin
        ext_a = {1'b0, opnd_a};
        ext_b = {1'b0, opnd_b};
        unique case (op)
            OP_PASS: wide = ext_a;
            OP_ADD:  wide = ext_a + ext_b;
            OP_SUB:  wide = ext_a - ext_b;
            OP_AND:  wide = ext_a & ext_b;
            OP_OR:   wide = ext_a | ext_b;
            OP_XOR:  wide = ext_a ^ ext_b;
            default: wide = '0;
        endcase
        result            = wide[W-1:0];
        flags[FLAG_ZERO]  = (wide[W-1:0] == '0);
        flags[FLAG_CARRY] = wide[W];
        flags[FLAG_NEG]   = wide[W-1];
    end

endmodule

// File: rtl/dp_select.sv
module dp_select
    import dp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [2:0]   res_sel,
    input  logic [1:0]   opa_sel,
    input  logic [W-1:0] mem_word,
    input  logic [W-1:0] imm_word,
    input  logic [W-1:0] port_a,
    input  logic [W-1:0] port_b,
    input  logic [W-1:0] alu_res,
    output logic [W-1:0] opnd_a,
    output logic [W-1:0] result
);

    always_comb begin
        unique case (opa_sel)
            OPA_MEM: opnd_a = mem_word;
            OPA_IMM: opnd_a = imm_word;
            OPA_PA:  opnd_a = port_a;
            default: opnd_a = '0;
        endcase
    end

    always_comb begin
        unique case (res_sel)
            RES_MEM: result = mem_word;
            RES_IMM: result = imm_word;
            RES_PA:  result = port_a;
            RES_PB:  result = port_b;
            RES_ALU: result = alu_res;
            default: result = '0;
        endcase
    end

endmodule

// File: rtl/dp_core.sv
module dp_core
    import dp_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [W-1:0]      mem_word,
    input  logic [W-1:0]      imm_word,
    input  logic              out_en,
    input  logic [2:0]        alu_op,
    input  logic [2:0]        res_sel,
    input  logic [1:0]        opa_sel,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] rd_addr_a,
    input  logic              rd_en_a,
    input  logic [ADDR_W-1:0] rd_addr_b,
    input  logic              rd_en_b,
    output logic [W-1:0]      dp_out,
    output logic [2:0]        flags
);

    logic [W-1:0] port_a;
    logic [W-1:0] port_b;
    logic [W-1:0] opnd_a;
    logic [W-1:0] alu_res;
    logic [W-1:0] result;

    dp_regfile #(.W(W), .NREG(REG_COUNT), .AW(ADDR_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (result),
        .rd_en_a   (rd_en_a),
        .rd_addr_a (rd_addr_a),
        .rd_en_b   (rd_en_b),
        .rd_addr_b (rd_addr_b),
        .rd_a      (port_a),
        .rd_b      (port_b)
    );

    dp_select #(.W(W)) u_sel (
        .res_sel  (res_sel),
        .opa_sel  (opa_sel),
        .mem_word (mem_word),
        .imm_word (imm_word),
        .port_a   (port_a),
        .port_b   (port_b),
        .alu_res  (alu_res),
        .opnd_a   (opnd_a),
        .result   (result)
    );

    dp_alu #(.W(W)) u_alu (
        .op     (alu_op),
        .opnd_a (opnd_a),
        .opnd_b (port_b),
        .result (alu_res),
        .flags  (flags)
    );

    always_comb begin
        dp_out = out_en ? result : '0;
    end

    // R4: a disabled port B routed out gives zero
    a_r4_idle_port: assert property (@(posedge clk) disable iff (rst)
        (out_en && res_sel == 3'd3 && !rd_en_b) |-> dp_out == '0);

    // R5: immediate source reaches the output unchanged
    a_r5_imm_route: assert property (@(posedge clk) disable iff (rst)
        (out_en && res_sel == 3'd1) |-> dp_out == imm_word);

    // R9: zero and sign flags agree with the ALU word seen at the output
    a_r9_zero_flag: assert property (@(posedge clk) disable iff (rst)
        (out_en && res_sel == 3'd4) |-> (flags[FLAG_ZERO] == (dp_out == '0)));
    a_r9_sign_flag: assert property (@(posedge clk) disable iff (rst)
        (out_en && res_sel == 3'd4) |-> (flags[FLAG_NEG] == dp_out[W-1]));

    // R8: a pass of the memory word shows that word at the output
    a_r8_pass_mem: assert property (@(posedge clk) disable iff (rst)
        (out_en && res_sel == 3'd4 && alu_op == 3'd0 && opa_sel == 2'd0) |-> dp_out == mem_word);

endmodule

// File: tb/dp_core_bench.sv
`timescale 1ns/1ps
module dp_core_bench;

    localparam int W = 32;
    localparam int N = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [W-1:0]  mem_word, imm_word;
    logic          out_en;
    logic [2:0]    alu_op, res_sel;
    logic [1:0]    opa_sel;
    logic [2:0]    wr_addr, rd_addr_a, rd_addr_b;
    logic          wr_en, rd_en_a, rd_en_b;
    logic [W-1:0]  dp_out;
    logic [2:0]    flags;

    int compared   = 0;
    int mismatched = 0;
    logic [W-1:0] model [N];

    always #4 clk = ~clk;

    dp_core #(.W(W)) u_dp_core (
        .clk(clk), .rst(rst), .mem_word(mem_word), .imm_word(imm_word),
        .out_en(out_en), .alu_op(alu_op), .res_sel(res_sel), .opa_sel(opa_sel),
        .wr_addr(wr_addr), .wr_en(wr_en), .rd_addr_a(rd_addr_a), .rd_en_a(rd_en_a),
        .rd_addr_b(rd_addr_b), .rd_en_b(rd_en_b), .dp_out(dp_out), .flags(flags)
    );

    // behavioural reference: result word and flags for the inputs now applied
    logic [W-1:0] exp_res;
    logic [W-1:0] exp_out;
    logic [2:0]   exp_flags;

    task automatic predict();
        longint unsigned pa, pb, a, b, r, msk;
        logic c;
        msk = (64'd1 << W) - 1;
        pa = rd_en_a ? longint'(model[rd_addr_a]) : 0;
        pb = rd_en_b ? longint'(model[rd_addr_b]) : 0;
        case (opa_sel)
            2'd0: a = longint'(mem_word);
            2'd1: a = longint'(imm_word);
            2'd2: a = pa;
            default: a = 0;
        endcase
        b = pb;
        c = 1'b0;
        case (alu_op)
            3'd0: r = a;
            3'd1: begin r = (a + b) & msk; c = ((a + b) >> W) != 0; end
            3'd2: begin r = (a - b) & msk; c = (a < b); end
            3'd3: r = a & b;
            3'd4: r = a | b;
            3'd5: r = a ^ b;
            default: r = 0;
        endcase
        exp_flags = {r[W-1], c, (r == 0)};
        case (res_sel)
            3'd0: exp_res = mem_word;
            3'd1: exp_res = imm_word;
            3'd2: exp_res = W'(pa);
            3'd3: exp_res = W'(pb);
            3'd4: exp_res = W'(r);
            default: exp_res = '0;
        endcase
        exp_out = out_en ? exp_res : '0;
    endtask

    function automatic string out_tag();
        if (!out_en) return "R7";
        case (res_sel)
            3'd2: return rd_en_a ? "R3" : "R4";
            3'd3: return rd_en_b ? "R3" : "R4";
            3'd4: return (opa_sel == 2'd3) ? "R6" : "R8";
            default: return "R5";
        endcase
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // apply inputs at the falling edge, compare mid-cycle, commit model at rising edge
    task automatic cycle(input string tag);
        #1;
        predict();
        check((tag == "") ? out_tag() : tag, dp_out, exp_out);
        check("R9", {29'd0, flags}, {29'd0, exp_flags});
        @(posedge clk);
        if (rst) begin
            for (int i = 0; i < N; i++) model[i] = '0;
        end else if (wr_en) begin
            model[wr_addr] = exp_res;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        rst = 0; wr_en = 0; out_en = 0; rd_en_a = 0; rd_en_b = 0;
        res_sel = 3'd0; opa_sel = 2'd0; alu_op = 3'd0;
        mem_word = '0; imm_word = '0;
        wr_addr = 0; rd_addr_a = 0; rd_addr_b = 0;
    endtask

    task automatic read_a(input logic [2:0] addr, input string tag);
        idle(); rd_en_a = 1; rd_addr_a = addr; res_sel = 3'd2; out_en = 1;
        cycle(tag);
    endtask

    task automatic read_b(input logic [2:0] addr, input string tag);
        idle(); rd_en_b = 1; rd_addr_b = addr; res_sel = 3'd3; out_en = 1;
        cycle(tag);
    endtask

    task automatic load_imm(input logic [2:0] dst, input logic [W-1:0] v);
        idle(); imm_word = v; res_sel = 3'd1; wr_addr = dst; wr_en = 1;
        cycle("R2");
    endtask

    task automatic do_reset();
        idle(); rst = 1;
        cycle("R1");
        for (int i = 0; i < N; i++) read_a(3'(i), "R1");
    endtask

    initial begin
        #150000;
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) model[i] = 'x;
        idle();
        rst = 1;
        @(negedge clk);
        // R1: reset clears the bank, every register reads zero afterwards
        do_reset();

        // R2/R3: constant loads visible in the very next cycle
        load_imm(3'd0, 32'd10);
        read_a(3'd0, "R3");
        load_imm(3'd1, 32'd20);
        read_a(3'd1, "R3");

        // R10: register-to-register move through port B
        idle(); rd_en_b = 1; rd_addr_b = 3'd1; res_sel = 3'd3; wr_addr = 3'd2; wr_en = 1;
        cycle("R10");
        read_a(3'd2, "R10");

        // R8: r2 = r2 + r0 -> 30, read on port B
        idle(); rd_en_a = 1; rd_addr_a = 3'd2; rd_en_b = 1; rd_addr_b = 3'd0;
        opa_sel = 2'd2; alu_op = 3'd1; res_sel = 3'd4; wr_addr = 3'd2; wr_en = 1;
        cycle("R8");
        read_b(3'd2, "R8");
        if (dp_out !== 32'd30) begin mismatched++; $display("FAIL R8: actual %0d expected 30", dp_out); end
        compared++;

        // R6: immediate on operand A: 2 + 40 = 42
        load_imm(3'd3, 32'd40);
        idle(); imm_word = 32'd2; opa_sel = 2'd1; rd_en_b = 1; rd_addr_b = 3'd3;
        alu_op = 3'd1; res_sel = 3'd4; wr_addr = 3'd3; wr_en = 1; out_en = 1;
        cycle("R6");
        read_a(3'd3, "R6");
        if (dp_out !== 32'd42) begin mismatched++; $display("FAIL R6: actual %0d expected 42", dp_out); end
        compared++;

        // R11: writes disabled with busy selects leave the bank intact
        idle(); mem_word = 32'hDEAD_BEEF; res_sel = 3'd0; wr_addr = 3'd3; out_en = 1;
        cycle("R11");
        read_a(3'd3, "R11");

        // R7: gated output still writes back
        idle(); imm_word = 32'h1234_5678; res_sel = 3'd1; wr_addr = 3'd5; wr_en = 1;
        cycle("R7");
        read_b(3'd5, "R7");

        // R9: borrow and carry corners
        load_imm(3'd4, 32'hFFFF_FFFF);
        idle(); imm_word = 32'd1; opa_sel = 2'd1; rd_en_b = 1; rd_addr_b = 3'd4;
        alu_op = 3'd1; res_sel = 3'd4; out_en = 1;
        cycle("R9");
        alu_op = 3'd2;
        cycle("R9");

        // random streams over every encoding
        for (int n = 0; n < 6000; n++) begin
            idle();
            rst       = ($urandom_range(0, 299) == 0);
            mem_word  = $urandom();
            imm_word  = ($urandom_range(0, 7) == 0) ? '0 : $urandom();
            out_en    = 1'($urandom());
            alu_op    = 3'($urandom());
            res_sel   = 3'($urandom());
            opa_sel   = 2'($urandom());
            wr_en     = 1'($urandom());
            wr_addr   = 3'($urandom());
            rd_en_a   = ($urandom_range(0, 3) != 0);
            rd_en_b   = ($urandom_range(0, 3) != 0);
            rd_addr_a = 3'($urandom());
            rd_addr_b = 3'($urandom());
            cycle(rst ? "R1" : "");
        end

        do_reset();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule